// File: doc/BRIEF.md
# Console I/O Register Block

This block is the device-register window of a small 16-bit processor. Processor loads and stores that fall in the top page of the address space reach five registers instead of general memory. Two of them hold keyboard state: a status word and the last received character. Two hold display state: a status word and an outgoing character. The fifth holds the run latch that keeps the processor executing.

Characters from a keyboard source arrive with a one-cycle strobe and are latched. Characters written by software leave through a valid/ready handshake to a display sink. Each device raises its own interrupt request when its flag is set and software has enabled it. The bus is single-cycle: a read returns data combinationally in the same cycle as the request, and a write takes effect at the clock edge that ends the request cycle.

Top module: `console_mmio`

## Requirements
- R1: `bus_hit` is high exactly when `bus_addr` >= 0xFE00. For any other address `bus_rdata` is 0 and a write changes no register.
- R2: Keyboard status (0xFE00) reads the ready flag in bit 15 and the interrupt enable in bit 14. All other bits read 0. Only bit 14 is writable.
- R3: A cycle with `kbd_strobe` high latches `kbd_char` and sets the keyboard ready flag. Keyboard data (0xFE02) returns that character in bits 7:0, with bits 15:8 zero.
- R4: A read of keyboard data clears the ready flag at the end of the read cycle. A strobe in that same cycle wins, and the flag stays set.
- R5: Display status (0xFE04) reads the done flag in bit 15 and the interrupt enable in bit 14. A write to bit 15 has no effect.
- R6: A write to display data (0xFE06) while done is set clears done and presents bits 7:0 on `disp_char` with `disp_valid` high. `disp_char` stays stable until a cycle with `disp_ready` high. Done sets at the end of that cycle.
- R7: A write to display data while done is clear is ignored: `disp_char` and the handshake are unchanged.
- R8: `kbd_irq` equals keyboard ready AND its enable. `disp_irq` equals display done AND its enable.
- R9: Machine control (0xFFFE) holds the run latch in bit 15, which drives `run`. Writing 0 to it clears `run` and writing 1 sets it. Other bits read 0.
- R10: After reset, `run` is 1 and display done is 1. Keyboard ready and both interrupt enables are 0.
- R11: Unassigned addresses inside the device page read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 16 | Store data |
| bus_rdata | output | 16 | Load data, valid in the request cycle |
| bus_hit | output | 1 | Address lies in the device page |
| kbd_strobe | input | 1 | New keyboard character present |
| kbd_char | input | 8 | Keyboard character |
| disp_valid | output | 1 | Outgoing character pending |
| disp_ready | input | 1 | Sink accepts the character |
| disp_char | output | 8 | Outgoing character |
| kbd_irq | output | 1 | Keyboard interrupt request |
| disp_irq | output | 1 | Display interrupt request |
| run | output | 1 | Run latch; 0 halts the processor |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, 8-bit characters, the device page starting at 0xFE00, and the control register at 0xFFFE. With these values it can probe both edges of the page (0xFDFE just below, 0xFE00 and 0xFFFE inside) and an unassigned hole at 0xFE08. It also covers the read/strobe collision on keyboard data and a display write issued while the previous character is still waiting for the sink.

// File: rtl/console_mmio_pkg.sv
package console_mmio_pkg;

    localparam int unsigned WORD_W  = 16;
    localparam int unsigned FLAG_B  = 15;
    localparam int unsigned IE_B    = 14;
    localparam int unsigned RUN_B   = 15;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_KSTAT = 3'd1,
        SEL_KDATA = 3'd2,
        SEL_DSTAT = 3'd3,
        SEL_DDATA = 3'd4,
        SEL_CTRL  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } bus_op_t;

    function automatic word_t status_word(input logic flag, input logic ie);
        word_t w;
        w         = '0;
        w[FLAG_B] = flag;
        w[IE_B]   = ie;
        return w;
    endfunction

endpackage

// File: rtl/con_addr_decode.sv
module con_addr_decode
    import console_mmio_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] IO_BASE = 16'hFE00,
    parameter logic [ADDR_W-1:0] KSTAT_A = 16'hFE00,
    parameter logic [ADDR_W-1:0] KDATA_A = 16'hFE02,
    parameter logic [ADDR_W-1:0] DSTAT_A = 16'hFE04,
    parameter logic [ADDR_W-1:0] DDATA_A = 16'hFE06,
    parameter logic [ADDR_W-1:0] CTRL_A  = 16'hFFFE
) (
    input  logic              valid,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output bus_op_t           op
);
    always_comb begin
        hit    = (addr >= IO_BASE);
        op.sel = SEL_NONE;
        if (hit) begin
            if      (addr == KSTAT_A) op.sel = SEL_KSTAT;
            else if (addr == KDATA_A) op.sel = SEL_KDATA;
            else if (addr == DSTAT_A) op.sel = SEL_DSTAT;
            else if (addr == DDATA_A) op.sel = SEL_DDATA;
            else if (addr == CTRL_A)  op.sel = SEL_CTRL;
        end
        op.rd = valid && !we && hit;
        op.wr = valid &&  we && hit;
    end
endmodule

// File: rtl/con_kbd_port.sv
module con_kbd_port #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              wr_stat,
    input  logic              ie_in,
    input  logic              rd_data,
    output logic              ready,
    output logic              ie,
    output logic [CHAR_W-1:0] char_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ready  <= 1'b0;
            ie     <= 1'b0;
            char_q <= '0;
        end else begin
            if (wr_stat) ie <= ie_in;
            if (strobe) begin
                ready  <= 1'b1;
                char_q <= char_in;
            end else if (rd_data) begin
                ready  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/con_disp_port.sv
module con_disp_port #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stat,
    input  logic              ie_in,
    input  logic              wr_data,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              out_ready,
    output logic              done,
    output logic              ie,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_char
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b1;
            ie       <= 1'b0;
            out_char <= '0;
        end else begin
            if (wr_stat) ie <= ie_in;
            if (done) begin
                if (wr_data) begin
                    done     <= 1'b0;
                    out_char <= char_in;
                end
            end else if (out_ready) begin
                done <= 1'b1;
            end
        end
    end

    assign out_valid = !done;
endmodule

// File: rtl/con_ctrl_reg.sv
module con_ctrl_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic run_in,
    output logic run
);
    always_ff @(posedge clk) begin
        if (rst)     run <= 1'b1;
        else if (wr) run <= run_in;
    end
endmodule

// File: rtl/console_mmio.sv
module console_mmio
    import console_mmio_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned CHAR_W  = 8,
    parameter logic [ADDR_W-1:0] IO_BASE = 16'hFE00,
    parameter logic [ADDR_W-1:0] KSTAT_A = 16'hFE00,
    parameter logic [ADDR_W-1:0] KDATA_A = 16'hFE02,
    parameter logic [ADDR_W-1:0] DSTAT_A = 16'hFE04,
    parameter logic [ADDR_W-1:0] DDATA_A = 16'hFE06,
    parameter logic [ADDR_W-1:0] CTRL_A  = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_hit,
    input  logic              kbd_strobe,
    input  logic [CHAR_W-1:0] kbd_char,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [CHAR_W-1:0] disp_char,
    output logic              kbd_irq,
    output logic              disp_irq,
    output logic              run
);
    localparam int unsigned PAD_W = WORD_W - CHAR_W;

    bus_op_t           op;
    logic              kbd_rdy, kbd_ie, dsp_done, dsp_ie;
    logic [CHAR_W-1:0] kbd_q;
    logic              unused_wbits;

    assign unused_wbits = ^bus_wdata[IE_B-1:CHAR_W];

    con_addr_decode #(
        .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .KSTAT_A(KSTAT_A), .KDATA_A(KDATA_A),
        .DSTAT_A(DSTAT_A), .DDATA_A(DDATA_A), .CTRL_A(CTRL_A)
    ) u_dec (
        .valid(bus_valid), .we(bus_we), .addr(bus_addr), .hit(bus_hit), .op(op)
    );

    con_kbd_port #(.CHAR_W(CHAR_W)) u_kbd (
        .clk(clk), .rst(rst), .strobe(kbd_strobe), .char_in(kbd_char),
        .wr_stat(op.wr && op.sel == SEL_KSTAT), .ie_in(bus_wdata[IE_B]),
        .rd_data(op.rd && op.sel == SEL_KDATA),
        .ready(kbd_rdy), .ie(kbd_ie), .char_q(kbd_q)
    );

    con_disp_port #(.CHAR_W(CHAR_W)) u_dsp (
        .clk(clk), .rst(rst),
        .wr_stat(op.wr && op.sel == SEL_DSTAT), .ie_in(bus_wdata[IE_B]),
        .wr_data(op.wr && op.sel == SEL_DDATA), .char_in(bus_wdata[CHAR_W-1:0]),
        .out_ready(disp_ready), .done(dsp_done), .ie(dsp_ie),
        .out_valid(disp_valid), .out_char(disp_char)
    );

    con_ctrl_reg u_ctl (
        .clk(clk), .rst(rst), .wr(op.wr && op.sel == SEL_CTRL),
        .run_in(bus_wdata[RUN_B]), .run(run)
    );

    always_comb begin
        bus_rdata = '0;
        if (op.rd) begin
            unique case (op.sel)
                SEL_KSTAT: bus_rdata = status_word(kbd_rdy, kbd_ie);
                SEL_KDATA: bus_rdata = {{PAD_W{1'b0}}, kbd_q};
                SEL_DSTAT: bus_rdata = status_word(dsp_done, dsp_ie);
                SEL_CTRL:  bus_rdata[RUN_B] = run;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign kbd_irq  = kbd_rdy  && kbd_ie;
    assign disp_irq = dsp_done && dsp_ie;
endmodule

// File: rtl/console_mmio_chk.sv
module console_mmio_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CHAR_W = 8,
    parameter logic [ADDR_W-1:0] KDATA_A = 16'hFE02,
    parameter logic [ADDR_W-1:0] CTRL_A  = 16'hFFFE
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic              bus_hit,
    input logic              kbd_strobe,
    input logic              kbd_rdy,
    input logic              disp_valid,
    input logic              disp_ready,
    input logic [CHAR_W-1:0] disp_char,
    input logic              disp_irq,
    input logic              run
);
    // R1: nothing is returned outside the device page
    a_r1_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_hit |-> bus_rdata == '0);

    // R3: a strobe always leaves the ready flag set
    a_r3_strobe_sets_ready: assert property (@(posedge clk) disable iff (rst)
        kbd_strobe |=> kbd_rdy);

    // R4: a load of keyboard data without a strobe drops ready
    a_r4_read_clears_ready: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_we && bus_addr == KDATA_A && !kbd_strobe) |=> !kbd_rdy);

    // R6: a pending character holds until accepted
    a_r6_char_stable: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_char)));

    // R8: display interrupt never while a character is pending
    a_r8_no_irq_when_busy: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> !disp_irq);

    // R9: a store of zero to the run bit halts
    a_r9_halt_on_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_we && bus_addr == CTRL_A && !bus_wdata[15]) |=> !run);
endmodule

bind console_mmio console_mmio_chk #(
    .ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .KDATA_A(KDATA_A), .CTRL_A(CTRL_A)
) u_chk (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_hit(bus_hit), .kbd_strobe(kbd_strobe), .kbd_rdy(kbd_rdy),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_char(disp_char),
    .disp_irq(disp_irq), .run(run)
);

// File: tb/console_mmio_tb.sv
module console_mmio_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0, bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_hit;
    logic        kbd_strobe = 1'b0;
    logic [7:0]  kbd_char = '0;
    logic        disp_valid, disp_ready = 1'b0;
    logic [7:0]  disp_char;
    logic        kbd_irq, disp_irq, run;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    console_mmio u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_hit(bus_hit), .kbd_strobe(kbd_strobe), .kbd_char(kbd_char),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_char(disp_char),
        .kbd_irq(kbd_irq), .disp_irq(disp_irq), .run(run)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    // Load: sample in the request cycle, before the edge that applies side effects
    task automatic rd(input logic [15:0] a, output logic [15:0] d, output logic h);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1; d = bus_rdata; h = bus_hit;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic kbd_send(input logic [7:0] c);
        @(negedge clk);
        kbd_strobe = 1'b1; kbd_char = c;
        @(negedge clk);
        kbd_strobe = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d; logic h;
        check("R10 run", {15'b0, run}, 16'h1);
        check("R10 disp_valid", {15'b0, disp_valid}, 16'h0);
        rd(16'hFE00, d, h); check("R10 kstat", d, 16'h0000);
        rd(16'hFE04, d, h); check("R10 dstat", d, 16'h8000);
        rd(16'hFFFE, d, h); check("R10 ctrl", d, 16'h8000);
        check("R10 irqs", {14'b0, kbd_irq, disp_irq}, 16'h0);
    endtask

    task automatic t_decode();
        logic [15:0] d; logic h;
        rd(16'hFDFE, d, h); check("R1 below hit", {15'b0, h}, 16'h0);
        check("R1 below data", d, 16'h0);
        rd(16'hFE00, d, h); check("R1 base hit", {15'b0, h}, 16'h1);
        rd(16'hFFFE, d, h); check("R1 top hit", {15'b0, h}, 16'h1);
        wr(16'h7E00, 16'h4000);
        rd(16'hFE00, d, h); check("R1 miss write ignored", d, 16'h0000);
        wr(16'hFE08, 16'hFFFF);
        rd(16'hFE08, d, h); check("R11 hole reads zero", d, 16'h0000);
        check("R11 hole write no halt", {15'b0, run}, 16'h1);
    endtask

    task automatic t_kbd();
        logic [15:0] d; logic h;
        wr(16'hFE00, 16'hBFFF); // bit14 clear, bit15 attempt
        rd(16'hFE00, d, h); check("R2 ready not writable", d, 16'h0000);
        kbd_send(8'h41);
        rd(16'hFE00, d, h); check("R3 ready set", d, 16'h8000);
        rd(16'hFE02, d, h); check("R3 char", d, 16'h0041);
        rd(16'hFE00, d, h); check("R4 read cleared ready", d, 16'h0000);
        // collision: strobe and data read in the same cycle
        kbd_send(8'h42);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = 16'hFE02;
        kbd_strobe = 1'b1; kbd_char = 8'h43;
        #1; check("R4 collision old char", bus_rdata, 16'h0042);
        @(negedge clk);
        bus_valid = 1'b0; kbd_strobe = 1'b0;
        rd(16'hFE00, d, h); check("R4 strobe wins", d, 16'h8000);
        rd(16'hFE02, d, h); check("R3 new char", d, 16'h0043);
    endtask

    task automatic t_irq();
        logic [15:0] d; logic h;
        wr(16'hFE00, 16'h4000);
        rd(16'hFE00, d, h); check("R2 ie readback", d, 16'h4000);
        check("R8 kbd irq idle", {15'b0, kbd_irq}, 16'h0);
        kbd_send(8'h55);
        #1; check("R8 kbd irq", {15'b0, kbd_irq}, 16'h1);
        rd(16'hFE02, d, h);
        #1; check("R8 kbd irq cleared", {15'b0, kbd_irq}, 16'h0);
        wr(16'hFE04, 16'h4000);
        #1; check("R8 disp irq", {15'b0, disp_irq}, 16'h1);
        rd(16'hFE04, d, h); check("R5 dstat", d, 16'hC000);
        wr(16'hFE04, 16'h0000);
        #1; check("R8 disp irq off", {15'b0, disp_irq}, 16'h0);
        wr(16'hFE00, 16'h0000);
    endtask

    task automatic t_disp();
        logic [15:0] d; logic h;
        wr(16'hFE06, 16'hAB5A);
        #1; check("R6 valid", {15'b0, disp_valid}, 16'h1);
        check("R6 char", {8'h0, disp_char}, 16'h005A);
        rd(16'hFE04, d, h); check("R6 done clear", d, 16'h0000);
        wr(16'hFE04, 16'h8000);
        rd(16'hFE04, d, h); check("R5 done not writable", d, 16'h0000);
        wr(16'hFE06, 16'h0033);
        #1; check("R7 busy write ignored", {8'h0, disp_char}, 16'h005A);
        check("R7 still valid", {15'b0, disp_valid}, 16'h1);
        @(negedge clk); disp_ready = 1'b1;
        @(negedge clk); disp_ready = 1'b0;
        check("R6 accepted", {15'b0, disp_valid}, 16'h0);
        rd(16'hFE04, d, h); check("R6 done set", d, 16'h8000);
        wr(16'hFE06, 16'h0021);
        #1; check("R6 second char", {8'h0, disp_char}, 16'h0021);
        @(negedge clk); disp_ready = 1'b1;
        @(negedge clk); disp_ready = 1'b0;
    endtask

    task automatic t_ctrl();
        logic [15:0] d; logic h;
        wr(16'hFFFE, 16'h7FFF);
        #1; check("R9 halt", {15'b0, run}, 16'h0);
        rd(16'hFFFE, d, h); check("R9 readback", d, 16'h0000);
        wr(16'hFFFE, 16'h8000);
        #1; check("R9 run again", {15'b0, run}, 16'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_decode();
        t_kbd();
        t_irq();
        t_disp();
        t_ctrl();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule